// File: doc/BRIEF.md
# Multiplexed VRAM Bus with Internal Address Latch

This block is the video-memory access path of a tile-rendering graphics controller. It owns a 14-bit memory address in which the low byte shares pins with the 8-bit data bus. The upper six address bits have pins of their own. An octal address latch, modelled inside the design, holds the low byte while the shared pins carry data. Every access takes two cycles. In the address cycle the controller drives all fourteen bits and pulses the latch enable. In the data cycle it drives only the high bits, and the memory returns a byte on the shared pins.

Two clients share the bus. The renderer issues fetch requests under a ready handshake. The CPU data port issues reads that pass through a short shift-register pipeline, so the port's latch pulse lands a fixed number of pixel dots after the CPU bus cycle. The port pulse always takes the low pins and the latch. If it lands inside a renderer fetch, the renderer's data cycle reads from a mixed address: the renderer's high bits joined with the port's low byte. The controller itself never drove that address. The effective address presented to memory is brought out as a debug port, so the hazard can be observed.

Top module: `vram_mux_bus`

## Requirements
- R1: A renderer request seen with `rend_ready_o` high in cycle n gives an address cycle in n+1 and a data cycle in n+2. In the address cycle `vram_ale_o` and `vram_ad_oe_o` are 1 and the low address byte is on `vram_ad_o`. In a data cycle with no port pulse, both are 0.
- R2: `eff_addr_o` always equals {high pins, latch value}. The latch is transparent while `vram_ale_o` is 1 and otherwise holds the last byte captured, whatever that byte is.
- R3: `fetch_done_o` is a one-cycle strobe in the cycle after the data cycle. `fetch_data_o` then carries the memory byte at the data cycle's effective address.
- R4: A port read strobed in cycle n produces a latch pulse in cycle n+PORT_DELAY (default 3) that drives the port address's low byte. The data cycle follows in the next cycle, and `port_done_o`/`port_data_o` follow one cycle after that.
- R5: When a port pulse lands in a renderer address or data cycle, the renderer's data cycle reads from {renderer high bits, port low byte}. Example: a fetch of 0x0F37 whose address cycle meets a port read of 0x2FFF reads from 0x0FFF.
- R6: `rend_ready_o` is 0 during a renderer address cycle and in any cycle that carries a port pulse, and 1 otherwise. A request made while it is 0 is dropped and starts no access.
- R7: The renderer drives the high pins in its address and data cycles. Otherwise, a port pulse cycle and the port data cycle drive the port's high bits. In any other cycle the pins keep their last value.
- R8: During reset, `rend_ready_o` is 1, and `vram_ale_o`, `fetch_done_o`, `port_done_o` and `eff_addr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rend_req_i | input | 1 | Renderer fetch request |
| rend_addr_i | input | 14 | Renderer fetch address |
| rend_ready_o | output | 1 | Renderer request will be accepted this cycle |
| port_rd_i | input | 1 | CPU data-port read strobe |
| port_addr_i | input | 14 | Address behind the data port |
| vram_hi_o | output | 6 | Dedicated high address pins |
| vram_ad_o | output | 8 | Shared pins, outgoing low address byte |
| vram_ad_oe_o | output | 1 | Output enable of the shared pins |
| vram_ad_i | input | 8 | Shared pins, incoming read data |
| vram_ale_o | output | 1 | Address latch enable |
| fetch_done_o | output | 1 | Renderer read result valid |
| fetch_data_o | output | 8 | Renderer read byte |
| port_done_o | output | 1 | Port read result valid |
| port_data_o | output | 8 | Port read byte |
| eff_addr_o | output | 14 | Address actually presented to memory |

## Verification
The properties assume that the memory answers combinationally from `eff_addr_o`, and that inputs are held low while reset is asserted. The bench drives inputs half a cycle away from the sampling edge and keeps every input at 0 during reset. Requests are sometimes raised while ready is low, deliberately. This is legal: the properties only demand an address cycle after a request that was actually accepted.

// File: rtl/vmx_pkg.sv
package vmx_pkg;

  // Renderer access phase
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ADDR = 2'd1,
    SEQ_DATA = 2'd2
  } seq_state_t;

endpackage

// File: rtl/vmx_port_pipe.sv
// Delays a CPU data-port read by DELAY dots before its latch pulse,
// then marks the following dot as the port's data cycle.
module vmx_port_pipe #(
  parameter int AW    = 14,
  parameter int DW    = 8,
  parameter int DELAY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_rd,
  input  logic [AW-1:0]    port_addr,
  output logic             fire,
  output logic [AW-1:0]    fire_addr,
  output logic             dphase,
  output logic [AW-DW-1:0] dphase_hi
);
  localparam int HW = AW - DW;

  logic [DELAY-1:0] vld_q, vld_d;
  logic [AW-1:0]    adr_q [DELAY];
  logic [AW-1:0]    adr_d [DELAY];
  logic             dph_q;
  logic [HW-1:0]    dph_hi_q;

  // Next-state: shift valid bits, move an address only with its valid bit
  always_comb begin
    vld_d[0] = port_rd;
    adr_d[0] = port_rd ? port_addr : adr_q[0];
    for (int i = 1; i < DELAY; i++) begin
      vld_d[i] = vld_q[i-1];
      adr_d[i] = vld_q[i-1] ? adr_q[i-1] : adr_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DELAY; i++) adr_q[i] <= '0;
    end else begin
      vld_q <= vld_d;
      for (int i = 0; i < DELAY; i++) adr_q[i] <= adr_d[i];
    end
  end

  assign fire      = vld_q[DELAY-1];
  assign fire_addr = adr_q[DELAY-1];

  // Data-cycle marker with the high bits it must keep on the pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dph_q    <= 1'b0;
      dph_hi_q <= '0;
    end else begin
      dph_q <= fire;
      if (fire) dph_hi_q <= fire_addr[AW-1:DW];
    end
  end

  assign dphase    = dph_q;
  assign dphase_hi = dph_hi_q;

endmodule

// File: rtl/vmx_fetch_seq.sv
// Two-cycle renderer access sequencer with a ready handshake.
module vmx_fetch_seq
  import vmx_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  input  logic          hold,
  output logic          ready,
  output logic          in_addr,
  output logic          in_data,
  output logic [AW-1:0] cur_addr
);
  seq_state_t    st_q, st_d;
  logic [AW-1:0] adr_q;
  logic          accept;

  // Refuse while the address cycle is on the pins, or while a port pulse
  // is on the bus (its data cycle would collide with our address cycle).
  assign ready  = (st_q != SEQ_ADDR) && !hold;
  assign accept = req && ready;

  always_comb begin
    st_d = st_q;
    case (st_q)
      SEQ_IDLE: if (accept) st_d = SEQ_ADDR;
      SEQ_ADDR: st_d = SEQ_DATA;
      SEQ_DATA: st_d = accept ? SEQ_ADDR : SEQ_IDLE;
      default:  st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      adr_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) adr_q <= req_addr;
    end
  end

  assign in_addr  = (st_q == SEQ_ADDR);
  assign in_data  = (st_q == SEQ_DATA);
  assign cur_addr = adr_q;

endmodule

// File: rtl/vmx_addr_latch.sv
// Octal address latch, modelled with a flop: transparent while le is high.
module vmx_addr_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          le,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  hold_q <= '0;
    else if (le) hold_q <= d;
  end

  assign q = le ? d : hold_q;

endmodule

// File: rtl/vram_mux_bus.sv
module vram_mux_bus #(
  parameter int AW         = 14,
  parameter int DW         = 8,
  parameter int PORT_DELAY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rend_req_i,
  input  logic [AW-1:0]    rend_addr_i,
  output logic             rend_ready_o,
  input  logic             port_rd_i,
  input  logic [AW-1:0]    port_addr_i,
  output logic [AW-DW-1:0] vram_hi_o,
  output logic [DW-1:0]    vram_ad_o,
  output logic             vram_ad_oe_o,
  input  logic [DW-1:0]    vram_ad_i,
  output logic             vram_ale_o,
  output logic             fetch_done_o,
  output logic [DW-1:0]    fetch_data_o,
  output logic             port_done_o,
  output logic [DW-1:0]    port_data_o,
  output logic [AW-1:0]    eff_addr_o
);
  localparam int HW = AW - DW;

  logic          fire, dphase;
  logic [AW-1:0] fire_addr;
  logic [HW-1:0] dphase_hi;
  logic          in_addr, in_data;
  logic [AW-1:0] seq_addr;
  logic          ale;
  logic [DW-1:0] lo_drv, lat_q;
  logic [HW-1:0] hi_now, hi_q;
  logic          fdone_q, pdone_q;
  logic [DW-1:0] fdata_q, pdata_q;

  vmx_port_pipe #(.AW(AW), .DW(DW), .DELAY(PORT_DELAY)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_rd   (port_rd_i),
    .port_addr (port_addr_i),
    .fire      (fire),
    .fire_addr (fire_addr),
    .dphase    (dphase),
    .dphase_hi (dphase_hi)
  );

  vmx_fetch_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (rend_req_i),
    .req_addr (rend_addr_i),
    .hold     (fire),
    .ready    (rend_ready_o),
    .in_addr  (in_addr),
    .in_data  (in_data),
    .cur_addr (seq_addr)
  );

  // Low pins: a port pulse wins over the renderer's address cycle
  assign ale    = fire | in_addr;
  assign lo_drv = fire ? fire_addr[DW-1:0] : seq_addr[DW-1:0];

  // High pins: renderer while it is mid-access, then the port, else hold
  always_comb begin
    if (in_addr || in_data) hi_now = seq_addr[AW-1:DW];
    else if (fire)          hi_now = fire_addr[AW-1:DW];
    else if (dphase)        hi_now = dphase_hi;
    else                    hi_now = hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else        hi_q <= hi_now;
  end

  vmx_addr_latch #(.DW(DW)) u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .le    (ale),
    .d     (lo_drv),
    .q     (lat_q)
  );

  // Result capture on each client's data cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fdone_q <= 1'b0;
      fdata_q <= '0;
      pdone_q <= 1'b0;
      pdata_q <= '0;
    end else begin
      fdone_q <= in_data;
      pdone_q <= dphase;
      if (in_data) fdata_q <= vram_ad_i;
      if (dphase)  pdata_q <= vram_ad_i;
    end
  end

  assign vram_hi_o    = hi_now;
  assign vram_ad_o    = lo_drv;
  assign vram_ad_oe_o = ale;
  assign vram_ale_o   = ale;
  assign fetch_done_o = fdone_q;
  assign fetch_data_o = fdata_q;
  assign port_done_o  = pdone_q;
  assign port_data_o  = pdata_q;
  assign eff_addr_o   = {hi_now, lat_q};

endmodule

// File: rtl/vmx_bus_chk.sv
module vmx_bus_chk #(
  parameter int AW = 14,
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rend_req_i,
  input logic             rend_ready_o,
  input logic [DW-1:0]    vram_ad_o,
  input logic             vram_ale_o,
  input logic             fetch_done_o,
  input logic             port_done_o,
  input logic [AW-1:0]    eff_addr_o
);
  // R1: an accepted request puts an address cycle on the pins next dot
  p_accept_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rend_req_i && rend_ready_o) |-> vram_ale_o);

  // R1: fetch result comes two dots after a latch pulse
  p_fetch_after_ale_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done_o |-> $past(vram_ale_o, 2));

  // R2: while the latch is open, memory sees the shared-pin byte
  p_ale_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vram_ale_o |-> (eff_addr_o[DW-1:0] == vram_ad_o));

  // R2: with the latch closed, the low address byte does not move
  p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !vram_ale_o |-> (eff_addr_o[DW-1:0] == $past(eff_addr_o[DW-1:0])));

  // R3: the fetch strobe lasts a single dot
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done_o |=> !fetch_done_o);

  // R4: port result two dots after its latch pulse
  p_port_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    port_done_o |-> $past(vram_ale_o, 2));

endmodule

bind vram_mux_bus vmx_bus_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rend_req_i   (rend_req_i),
  .rend_ready_o (rend_ready_o),
  .vram_ad_o    (vram_ad_o),
  .vram_ale_o   (vram_ale_o),
  .fetch_done_o (fetch_done_o),
  .port_done_o  (port_done_o),
  .eff_addr_o   (eff_addr_o)
);

// File: tb/sim_vram_mux_bus.sv
module sim_vram_mux_bus;
  localparam int AW  = 14;
  localparam int DW  = 8;
  localparam int DLY = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rend_req_i = 1'b0;
  logic [AW-1:0] rend_addr_i = '0;
  logic          port_rd_i = 1'b0;
  logic [AW-1:0] port_addr_i = '0;
  logic          rend_ready_o, vram_ad_oe_o, vram_ale_o, fetch_done_o, port_done_o;
  logic [5:0]    vram_hi_o;
  logic [DW-1:0] vram_ad_o, vram_ad_i, fetch_data_o, port_data_o;
  logic [AW-1:0] eff_addr_o;

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit run = 0;
  bit ended = 0;
  int r_at[int];     // renderer address cycles -> address
  int p_at[int];     // port pulse cycles -> address
  int effh[int];     // modelled effective address per cycle
  int want_eff[int]; // hand-computed addresses for directed cases
  int want_fd[int];  // hand-computed fetch bytes
  int hi_m = 0;
  int lat_m = 0;

  function automatic int memf(int a);
    return ((a & 255) ^ (((a >> 8) & 63) * 29)) & 255;
  endfunction

  assign vram_ad_i = 8'(memf(int'(eff_addr_o)));

  vram_mux_bus #(.AW(AW), .DW(DW), .PORT_DELAY(DLY)) u0 (
    .clk(clk), .rst_n(rst_n),
    .rend_req_i(rend_req_i), .rend_addr_i(rend_addr_i), .rend_ready_o(rend_ready_o),
    .port_rd_i(port_rd_i), .port_addr_i(port_addr_i),
    .vram_hi_o(vram_hi_o), .vram_ad_o(vram_ad_o), .vram_ad_oe_o(vram_ad_oe_o),
    .vram_ad_i(vram_ad_i), .vram_ale_o(vram_ale_o),
    .fetch_done_o(fetch_done_o), .fetch_data_o(fetch_data_o),
    .port_done_o(port_done_o), .port_data_o(port_data_o),
    .eff_addr_o(eff_addr_o)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // Reference model: one step per dot, compared at the falling edge
  task automatic model(int n);
    bit rA = r_at.exists(n);
    bit rD = r_at.exists(n - 1);
    bit pF = p_at.exists(n);
    bit pD = p_at.exists(n - 1);
    bit ale;
    int lo, hi, eff;
    ale = rA || pF;
    lo  = pF ? (p_at[n] & 255) : (rA ? (r_at[n] & 255) : 0);
    if (rA)      hi = r_at[n] >> 8;
    else if (rD) hi = r_at[n-1] >> 8;
    else if (pF) hi = p_at[n] >> 8;
    else if (pD) hi = p_at[n-1] >> 8;
    else         hi = hi_m;
    eff = (hi << 8) | (ale ? lo : lat_m);
    effh[n] = eff;
    if (ale) lat_m = lo;
    hi_m = hi;
    chk(vram_ale_o == ale, "R1", "latch enable", int'(vram_ale_o), int'(ale));
    chk(vram_ad_oe_o == ale, "R1", "pin drive", int'(vram_ad_oe_o), int'(ale));
    if (ale) chk(int'(vram_ad_o) == lo, "R4", "low pins", int'(vram_ad_o), lo);
    chk(int'(vram_hi_o) == hi, "R7", "high pins", int'(vram_hi_o), hi);
    chk(int'(eff_addr_o) == eff, "R2", "effective address", int'(eff_addr_o), eff);
    chk(rend_ready_o == !(rA || pF), "R6", "ready", int'(rend_ready_o), int'(!(rA || pF)));
    chk(fetch_done_o == r_at.exists(n - 2), "R3", "fetch done", int'(fetch_done_o),
        int'(r_at.exists(n - 2)));
    if (r_at.exists(n - 2))
      chk(int'(fetch_data_o) == memf(effh[n-1]), "R3", "fetch data", int'(fetch_data_o),
          memf(effh[n-1]));
    chk(port_done_o == p_at.exists(n - 2), "R4", "port done", int'(port_done_o),
        int'(p_at.exists(n - 2)));
    if (p_at.exists(n - 2))
      chk(int'(port_data_o) == memf(effh[n-1]), "R4", "port data", int'(port_data_o),
          memf(effh[n-1]));
    if (want_eff.exists(n))
      chk(eff == want_eff[n] && int'(eff_addr_o) == want_eff[n], "R5", "directed address",
          int'(eff_addr_o), want_eff[n]);
    if (want_fd.exists(n))
      chk(int'(fetch_data_o) == want_fd[n], "R5", "directed fetch byte",
          int'(fetch_data_o), want_fd[n]);
  endtask

  always @(negedge clk) if (run) model(cyc);

  // Drive one dot of stimulus; records what the requirements say will follow
  task automatic drive(input bit dr, input int ra, input bit dp, input int pa, output int n);
    bit rdy;
    @(negedge clk);
    n   = cyc;
    rdy = !(r_at.exists(n) || p_at.exists(n));
    rend_req_i  = dr;
    rend_addr_i = AW'(ra);
    port_rd_i   = dp;
    port_addr_i = AW'(pa);
    if (dr && rdy) r_at[n + 1] = ra;   // R6: dropped when not ready
    if (dp)        p_at[n + DLY] = pa;
  endtask

  task automatic idle(int k);
    int n;
    for (int i = 0; i < k; i++) drive(0, 0, 0, 0, n);
  endtask

  initial begin
    int n, j;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(rend_ready_o == 1'b1, "R8", "ready in reset", int'(rend_ready_o), 1);
    chk(vram_ale_o == 1'b0, "R8", "ale in reset", int'(vram_ale_o), 0);
    chk(fetch_done_o == 1'b0 && port_done_o == 1'b0, "R8", "done in reset",
        int'(fetch_done_o | port_done_o), 0);
    chk(eff_addr_o == '0, "R8", "address in reset", int'(eff_addr_o), 0);
    rst_n = 1'b1;
    @(posedge clk);
    run = 1;

    // R1/R3: one clean fetch
    drive(1, 'h1A5C, 0, 0, n);
    want_eff[n+1] = 'h1A5C;
    want_eff[n+2] = 'h1A5C;
    idle(4);

    // R1/R6: request every dot; those in address cycles are dropped
    for (int i = 0; i < 12; i++) drive(1, 'h0100 + i * 'h111, 0, 0, n);
    idle(4);

    // R4: lone port read
    drive(0, 0, 1, 'h2345, n);
    want_eff[n+3] = 'h2345;
    want_eff[n+4] = 'h2345;
    idle(6);

    // Benign port reads interleaved with fetches: no hybrid addresses
    for (int i = 0; i < 16; i++) begin
      int ra = $urandom & 'h3FFF;
      int pa = $urandom & 'h3FFF;
      drive(1, ra, 1, pa, n);
      want_eff[n+2] = ra;
      want_eff[n+4] = pa;
      idle(3);
    end
    idle(3);

    // R5: port pulse on the fetch's address cycle -> 0x0FFF
    drive(0, 0, 1, 'h2FFF, j);
    idle(1);
    drive(1, 'h0F37, 0, 0, n);
    want_eff[j+4] = 'h0FFF;
    want_fd[j+5]  = memf('h0FFF);
    idle(6);

    // R5/R2: port pulse on the fetch's data cycle; stale byte is 0x56
    drive(0, 0, 1, 'h3456, j);
    drive(1, 'h1234, 0, 0, n);
    want_eff[j+3] = 'h1256;
    want_eff[j+4] = 'h3456;
    want_fd[j+4]  = memf('h1256);
    idle(6);

    // Mixed traffic
    for (int i = 0; i < 300; i++)
      drive(($urandom % 3) == 0, $urandom & 'h3FFF, ($urandom % 5) == 0,
            $urandom & 'h3FFF, n);
    idle(8);
    finish_run();
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

endmodule